// File: doc/BRIEF.md
# Triggered PID Compensator

This block is the compensator stage of a digital power control loop. It holds a proportional, an integral and a derivative term in fixed point and computes one new control output each time it is triggered. A trigger is either the conversion-complete strobe of the error ADC or a start bit written by firmware. The output then feeds the PWM duty path. Between triggers the block is idle, and its output and saturation status stay where the last calculation left them.

Firmware configures the block through a simple write-enable register bus. It loads the three gains and picks the error source: the live ADC error or a signed sample held in a register, which allows open-loop tests. Per-term bits can zero a term or freeze it. A signed shift code scales the sum before it is clamped to the output width. A mode bit is stored and exposed for the downstream nonlinear stage.

Top module: `trig_pid`

## Requirements
- R1: After reset the enable bit is 1, the select, force, off, stall and mode bits are 0, the shift code is 0, the gains and the register sample are 0, and `dutyOut`, `outValid` and `satStatus` are 0.
- R2: A high `adcValid` at clock edge k, while enabled, latches the error at edge k. At edge k+1 it computes the result, so `outValid` is high for exactly the one cycle after edge k+1.
- R3: Writing 1 to control bit 2 (force start) to address 0 starts exactly one calculation, with the same timing as R2 counted from the edge after the write. The bit clears itself on the next clock.
- R4: When control bit 1 is 1, the calculation uses the signed sample at address 1 instead of `adcErr`. When it is 0, a force start uses `adcErr`.
- R5: With error e, gains at addresses 2 (Kp), 3 (Ki) and 4 (Kd), and previous error ep: the integral state becomes I' = I + Ki*e, the derivative term is D = Kd*(e - ep), and the output is Kp*e + I' + D.
- R6: Control bits 3, 4 and 5 (P, I and D off) make the matching term contribute 0. The integral state, the held derivative and the previous error become 0 only when a calculation runs while the bit is set. Setting and then clearing a bit with no calculation in between changes no state.
- R7: Control bits 6 and 7 (I stall, D stall) keep the integral state, or the held derivative term and the previous error, unchanged through a calculation. The frozen value is still added to the output.
- R8: Control bits 11:9 hold a two's-complement shift code. A code n from 0 to 3 shifts the sum arithmetically right by n. A code from -4 to -1 shifts it left by |n|.
- R9: A scaled result outside the 24-bit signed range is clamped to 8388607 or -8388608, and `satStatus` is 1. An in-range result sets `satStatus` to 0.
- R10: While control bit 0 (enable) is 0, ADC and force triggers start no calculation, and `dutyOut` and `satStatus` hold their last values. `dutyOut` and `satStatus` change only in cycles where `outValid` is high.
- R11: Control bit 8 (mode) appears on `nlModeOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| adcValid | input | 1 | Conversion-complete strobe from the error ADC |
| adcErr | input | 16 | Signed error sample from the ADC |
| outValid | output | 1 | One-cycle pulse marking a new result |
| dutyOut | output | 24 | Signed, scaled and clamped compensator output |
| satStatus | output | 1 | 1 when the last result was clamped |
| nlModeOut | output | 1 | Stored nonlinear mode selection |

## Verification
The assertions check the following on every cycle:
- each calculation strobe yields exactly one following `outValid`;
- the force bit clears itself;
- the output and the status move only on a valid pulse;
- no calculation starts while the block is disabled;
- the integral state stays fixed between calculations, is zeroed by a calculation run with the I-off bit set, and is frozen by a stall.

Only the bench scenarios can show the following:
- the arithmetic values of the PID recurrence;
- the source selection;
- that an off bit set and cleared without a trigger leaves the history intact;
- the direction of the shift for each code;
- the clamp limits at both ends of the output range.

// File: rtl/pid_pkg.sv
package pid_pkg;

  localparam int SCALE_W = 3;

  localparam int BIT_EN     = 0;
  localparam int BIT_CPU    = 1;
  localparam int BIT_FORCE  = 2;
  localparam int BIT_POFF   = 3;
  localparam int BIT_IOFF   = 4;
  localparam int BIT_DOFF   = 5;
  localparam int BIT_ISTALL = 6;
  localparam int BIT_DSTALL = 7;
  localparam int BIT_NL     = 8;
  localparam int BIT_SCALE  = 9;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_SAMPLE = 1;
  localparam int ADDR_COEF0  = 2;
  localparam int NUM_COEF    = 3;

  typedef struct packed {
    logic capture;
    logic compute;
  } strobe_t;

  typedef struct packed {
    logic               enable;
    logic               useCpu;
    logic               pOff;
    logic               iOff;
    logic               dOff;
    logic               iStall;
    logic               dStall;
    logic               nlMode;
    logic [SCALE_W-1:0] scale;
  } cfg_t;

endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     adcValid,
  output strobe_t                  strobes,
  output cfg_t                     cfg,
  output logic                     forcePend,
  output logic signed [DATA_W-1:0] cpuSample,
  output logic signed [DATA_W-1:0] kp,
  output logic signed [DATA_W-1:0] ki,
  output logic signed [DATA_W-1:0] kd
);

  localparam int CTRL_USED = BIT_SCALE + SCALE_W;

  logic ctrlSel;
  logic sampleSel;
  logic trigger;
  logic computeQ;
  logic signed [DATA_W-1:0] coef [NUM_COEF];
  logic unusedCtrlHigh;

  assign ctrlSel   = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
  assign sampleSel = wrEn && (wrAddr == ADDR_W'(ADDR_SAMPLE));
  assign unusedCtrlHigh = ^wrData[DATA_W-1:CTRL_USED];

  // Configuration bits (R1 reset values, R11 mode bit)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.enable <= 1'b1;
      cfg.useCpu <= 1'b0;
      cfg.pOff   <= 1'b0;
      cfg.iOff   <= 1'b0;
      cfg.dOff   <= 1'b0;
      cfg.iStall <= 1'b0;
      cfg.dStall <= 1'b0;
      cfg.nlMode <= 1'b0;
      cfg.scale  <= '0;
    end else if (ctrlSel) begin
      cfg.enable <= wrData[BIT_EN];
      cfg.useCpu <= wrData[BIT_CPU];
      cfg.pOff   <= wrData[BIT_POFF];
      cfg.iOff   <= wrData[BIT_IOFF];
      cfg.dOff   <= wrData[BIT_DOFF];
      cfg.iStall <= wrData[BIT_ISTALL];
      cfg.dStall <= wrData[BIT_DSTALL];
      cfg.nlMode <= wrData[BIT_NL];
      cfg.scale  <= wrData[BIT_SCALE +: SCALE_W];
    end
  end

  // Force start: lives for one cycle, then clears itself (R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        forcePend <= 1'b0;
    else if (ctrlSel) forcePend <= wrData[BIT_FORCE];
    else              forcePend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cpuSample <= '0;
    else if (sampleSel) cpuSample <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_COEF; g++) coef[g] <= '0;
    end else if (wrEn) begin
      for (int g = 0; g < NUM_COEF; g++)
        if (wrAddr == ADDR_W'(ADDR_COEF0 + g)) coef[g] <= wrData;
    end
  end

  assign kp = coef[0];
  assign ki = coef[1];
  assign kd = coef[2];

  // Trigger gating (R2, R10): latch now, compute on the next edge
  assign trigger = cfg.enable && (adcValid || forcePend);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) computeQ <= 1'b0;
    else       computeQ <= trigger;
  end

  assign strobes.capture = trigger;
  assign strobes.compute = computeQ;

endmodule

// File: rtl/pid_datapath.sv
module pid_datapath
  import pid_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobes,
  input  cfg_t                     cfg,
  input  logic signed [DATA_W-1:0] adcErr,
  input  logic signed [DATA_W-1:0] cpuSample,
  input  logic signed [DATA_W-1:0] kp,
  input  logic signed [DATA_W-1:0] ki,
  input  logic signed [DATA_W-1:0] kd,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  dutyOut,
  output logic                     satStatus,
  output logic signed [ACC_W-1:0]  iHist
);

  localparam int MUL_W     = 2 * DATA_W + 1;
  localparam int WIDE_W    = ((MUL_W > ACC_W + 2) ? MUL_W : ACC_W + 2) + 1;
  localparam int SHIFT_MAX = 1 << (SCALE_W - 1);
  localparam int EXT_W     = WIDE_W + SHIFT_MAX;

  localparam logic signed [WIDE_W-1:0] ACC_MAX =
    {{(WIDE_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] ACC_MIN =
    {{(WIDE_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic signed [EXT_W-1:0] OUT_MAX =
    {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [EXT_W-1:0] OUT_MIN =
    {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] clampAcc(input logic signed [WIDE_W-1:0] v);
    if (v > ACC_MAX)      return ACC_MAX[ACC_W-1:0];
    else if (v < ACC_MIN) return ACC_MIN[ACC_W-1:0];
    else                  return v[ACC_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] sampleReg;
  logic signed [DATA_W-1:0] ePrev;
  logic signed [ACC_W-1:0]  iAcc;
  logic signed [ACC_W-1:0]  dHold;

  logic signed [WIDE_W-1:0] pProd, iProd, dDiff, dProd, iSum, uSum;
  logic signed [ACC_W-1:0]  pTerm, iNext, dNext;
  logic signed [DATA_W-1:0] ePrevNext;
  logic signed [EXT_W-1:0]  uExt, uShift;
  logic [SCALE_W-1:0]       leftAmt;
  logic signed [OUT_W-1:0]  dutyNext;
  logic                     satNext;
  logic                     unusedCfg;

  assign unusedCfg = cfg.enable ^ cfg.nlMode;

  // Term arithmetic (R5)
  always_comb begin
    pProd = WIDE_W'(kp) * WIDE_W'(sampleReg);
    iProd = WIDE_W'(ki) * WIDE_W'(sampleReg);
    dDiff = WIDE_W'(sampleReg) - WIDE_W'(ePrev);
    dProd = WIDE_W'(kd) * dDiff;
    iSum  = WIDE_W'(iAcc) + iProd;
  end

  // Off and stall selection (R6, R7); off has priority over stall
  always_comb begin
    pTerm = cfg.pOff ? '0 : clampAcc(pProd);

    if (cfg.iOff)        iNext = '0;
    else if (cfg.iStall) iNext = iAcc;
    else                 iNext = clampAcc(iSum);

    if (cfg.dOff) begin
      dNext     = '0;
      ePrevNext = '0;
    end else if (cfg.dStall) begin
      dNext     = dHold;
      ePrevNext = ePrev;
    end else begin
      dNext     = clampAcc(dProd);
      ePrevNext = sampleReg;
    end
  end

  // Sum, signed shift (R8) and output clamp (R9)
  always_comb begin
    uSum    = WIDE_W'(pTerm) + WIDE_W'(iNext) + WIDE_W'(dNext);
    uExt    = EXT_W'(uSum);
    leftAmt = ~cfg.scale + SCALE_W'(1);
    if (cfg.scale[SCALE_W-1]) uShift = uExt <<< leftAmt;
    else                      uShift = uExt >>> cfg.scale;

    if (uShift > OUT_MAX) begin
      dutyNext = OUT_MAX[OUT_W-1:0];
      satNext  = 1'b1;
    end else if (uShift < OUT_MIN) begin
      dutyNext = OUT_MIN[OUT_W-1:0];
      satNext  = 1'b1;
    end else begin
      dutyNext = uShift[OUT_W-1:0];
      satNext  = 1'b0;
    end
  end

  // Input latch on capture (R4), state update on compute (R2, R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleReg <= '0;
      ePrev     <= '0;
      iAcc      <= '0;
      dHold     <= '0;
      dutyOut   <= '0;
      satStatus <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strobes.compute;
      if (strobes.capture)
        sampleReg <= cfg.useCpu ? cpuSample : adcErr;
      if (strobes.compute) begin
        iAcc      <= iNext;
        dHold     <= dNext;
        ePrev     <= ePrevNext;
        dutyOut   <= dutyNext;
        satStatus <= satNext;
      end
    end
  end

  assign iHist = iAcc;

endmodule

// File: rtl/trig_pid.sv
module trig_pid
  import pid_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcErr,
  output logic              outValid,
  output logic [OUT_W-1:0]  dutyOut,
  output logic              satStatus,
  output logic              nlModeOut
);

  strobe_t strobes;
  cfg_t    cfg;
  logic    forcePend;
  logic signed [DATA_W-1:0] cpuSample, kp, ki, kd;
  logic signed [ACC_W-1:0]  iHist;
  logic signed [OUT_W-1:0]  dutySigned;

  pid_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .adcValid  (adcValid),
    .strobes   (strobes),
    .cfg       (cfg),
    .forcePend (forcePend),
    .cpuSample (cpuSample),
    .kp        (kp),
    .ki        (ki),
    .kd        (kd)
  );

  pid_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cfg       (cfg),
    .adcErr    ($signed(adcErr)),
    .cpuSample (cpuSample),
    .kp        (kp),
    .ki        (ki),
    .kd        (kd),
    .outValid  (outValid),
    .dutyOut   (dutySigned),
    .satStatus (satStatus),
    .iHist     (iHist)
  );

  assign dutyOut   = dutySigned;
  assign nlModeOut = cfg.nlMode;

endmodule

// File: rtl/trig_pid_chk.sv
module trig_pid_chk
  import pid_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 24,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              outValid,
  input logic [OUT_W-1:0]  dutyOut,
  input logic              satStatus,
  input strobe_t           strobes,
  input cfg_t              cfg,
  input logic              forcePend,
  input logic [ACC_W-1:0]  iHist
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.compute |=> outValid);

  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobes.compute));

  assert_force_selfclear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (forcePend && !(wrEn && wrAddr == ADDR_W'(ADDR_CTRL))) |=> !forcePend);

  assert_hist_zeroed_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.compute && cfg.iOff) |=> (iHist == '0));

  assert_hist_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.compute |=> $stable(iHist));

  assert_hist_stalled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.compute && cfg.iStall && !cfg.iOff) |=> $stable(iHist));

  assert_output_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(dutyOut) && $stable(satStatus)));

  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> !strobes.compute);

endmodule

bind trig_pid trig_pid_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .outValid  (outValid),
  .dutyOut   (dutyOut),
  .satStatus (satStatus),
  .strobes   (strobes),
  .cfg       (cfg),
  .forcePend (forcePend),
  .iHist     (iHist)
);

// File: tb/test_trig_pid.sv
`timescale 1ns/1ps
module test_trig_pid;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        adcValid = 1'b0;
  logic [15:0] adcErr = '0;
  logic        outValid;
  logic [23:0] dutyOut;
  logic        satStatus;
  logic        nlModeOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trig_pid i_trig_pid (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .adcValid(adcValid), .adcErr(adcErr), .outValid(outValid),
    .dutyOut(dutyOut), .satStatus(satStatus), .nlModeOut(nlModeOut)
  );

  localparam int NV = 5;
  localparam logic signed [15:0] VEC_E [NV] = '{16'sd10, -16'sd4, 16'sd7, 16'sd7, 16'sd0};
  localparam int VEC_U [NV] = '{60, -44, 60, 34, -1};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrlWord(input bit en, input bit cpu, input bit frc,
      input bit pOff, input bit iOff, input bit dOff, input bit iSt, input bit dSt,
      input bit nl, input logic [2:0] sc);
    return {4'b0, sc, nl, dSt, iSt, dOff, iOff, pOff, frc, cpu, en};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runAdc(input logic signed [15:0] e, output bit v, output int u);
    @(negedge clk);
    adcErr = e; adcValid = 1'b1;
    @(negedge clk);
    adcValid = 1'b0;
    @(negedge clk);
    v = outValid;
    u = $signed(dutyOut);
  endtask

  task automatic waitForce(output bit v, output int u);
    @(negedge clk);
    @(negedge clk);
    v = outValid;
    u = $signed(dutyOut);
  endtask

  function automatic int duty();
    return $signed(dutyOut);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit v;
    int u;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 dutyOut", duty(), 0);
    chk("R1 outValid", int'(outValid), 0);
    chk("R1 satStatus", int'(satStatus), 0);
    chk("R1 nlModeOut", int'(nlModeOut), 0);
    runAdc(16'sd0, v, u);
    chk("R1 enabled at reset", int'(v), 1);
    chk("R1 zero gains", u, 0);

    // R2 R5 vector table: Kp=2 Ki=1 Kd=3
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd1);
    wr(3'd4, 16'd3);
    for (int n = 0; n < NV; n++) begin
      runAdc(VEC_E[n], v, u);
      chk("R2 valid pulse", int'(v), 1);
      chk("R5 pid output", u, VEC_U[n]);
      @(negedge clk);
      chk("R2 single cycle", int'(outValid), 0);
    end

    // R3 R4 force start with register sample -34 (I=20, ep=0)
    wr(3'd1, 16'hFFDE);
    wr(3'd0, ctrlWord(1,1,1,0,0,0,0,0,0,3'd0));
    waitForce(v, u);
    chk("R3 force valid", int'(v), 1);
    chk("R4 cpu sample", u, -184);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      chk("R3 exactly one run", int'(outValid), 0);
    end
    runAdc(16'sd1000, v, u);
    chk("R4 adc ignored when cpu selected", u, -116);
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd0));

    // R3 R4 force start with live ADC input 5 (I=-48, ep=-34)
    adcErr = 16'sd5;
    wr(3'd0, ctrlWord(1,0,1,0,0,0,0,0,0,3'd0));
    waitForce(v, u);
    chk("R3 force uses adc valid", int'(v), 1);
    chk("R4 force uses adc", u, 84);

    // R6 off bits toggled without a trigger keep history (I=-43, ep=5)
    wr(3'd0, ctrlWord(1,0,0,0,1,1,0,0,0,3'd0));
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd0));
    runAdc(16'sd5, v, u);
    chk("R6 history kept", u, -28);

    // R6 off bits with a trigger clear history
    wr(3'd0, ctrlWord(1,0,0,1,1,1,0,0,0,3'd0));
    runAdc(16'sd9, v, u);
    chk("R6 all terms off", u, 0);
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd0));
    runAdc(16'sd9, v, u);
    chk("R6 history cleared", u, 54);

    // R7 stall keeps I=9, D=27, ep=9
    wr(3'd0, ctrlWord(1,0,0,0,0,0,1,1,0,3'd0));
    runAdc(16'sd4, v, u);
    chk("R7 stalled terms", u, 44);
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd0));
    runAdc(16'sd4, v, u);
    chk("R7 released from stall", u, 6);

    // R8 shift codes, Ki=Kd=0 so I stays 13, u = 2e + 13
    wr(3'd3, 16'd0);
    wr(3'd4, 16'd0);
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd2));
    runAdc(16'sd20, v, u);
    chk("R8 right by 2", u, 13);
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd5));
    runAdc(16'sd20, v, u);
    chk("R8 left by 3", u, 424);
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd1));
    runAdc(-16'sd20, v, u);
    chk("R8 arithmetic right of negative", u, -14);

    // R9 saturation with Kp=32767 and shift left by 4
    wr(3'd2, 16'h7FFF);
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd4));
    runAdc(16'sd32767, v, u);
    chk("R9 clamp high", u, 8388607);
    chk("R9 status high", int'(satStatus), 1);
    runAdc(-16'sd32768, v, u);
    chk("R9 clamp low", u, -8388608);
    chk("R9 status low", int'(satStatus), 1);

    // R10 disabled: triggers ignored, output and status held
    wr(3'd0, ctrlWord(0,0,0,0,0,0,0,0,0,3'd0));
    runAdc(16'sd0, v, u);
    chk("R10 adc ignored", int'(v), 0);
    chk("R10 duty held", u, -8388608);
    chk("R10 status held", int'(satStatus), 1);
    wr(3'd0, ctrlWord(0,0,1,0,0,0,0,0,0,3'd0));
    waitForce(v, u);
    chk("R10 force ignored", int'(v), 0);
    chk("R10 duty held after force", u, -8388608);
    wr(3'd2, 16'd2);
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,0,3'd0));
    runAdc(16'sd1, v, u);
    chk("R10 resumes", u, 15);
    chk("R9 status clears", int'(satStatus), 0);

    // R11 mode bit
    wr(3'd0, ctrlWord(1,0,0,0,0,0,0,0,1,3'd0));
    @(negedge clk);
    chk("R11 mode out", int'(nlModeOut), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule